// File: doc/BRIEF.md
# Two-Level Round-Based Channel Issue Scheduler

This block decides which of a set of transfer channels may issue its next transfer. A channel can be picked when its request bit and its enable bit are both set. A per-channel urgency bit sorts channels into two classes. Scheduling runs in rounds. A round first visits every requesting urgent channel once, then serves exactly one requesting ordinary channel, and then a new round starts. Ordinary traffic is interleaved with urgent traffic and cannot be starved. The urgency bit only changes the issue order. The block drives no bus-level priority of any kind.

The result is a registered one-hot grant with a valid flag. A grant stays in place until the issue stage pulses the accept strobe. A decision taken at one clock edge appears at the outputs in the following cycle. Within each class a rotating pointer starts the search just after the channel last accepted in that class.

Top module: `dma_round_sched`

## Requirements
- R1: After reset no grant is outstanding and both class pointers are at channel 0. The first decision therefore picks the lowest-numbered eligible channel of the class being searched.
- R2: Within a round, each eligible urgent channel (urgency bit 1) is granted at most once. All of them are granted before any ordinary channel.
- R3: Once the urgent channels of a round are used up, exactly one ordinary channel (urgency bit 0) is granted. Its acceptance closes the round, and urgent channels become grantable again.
- R4: Each class searches upward from the channel just after its last accepted channel, wrapping from the highest channel back to channel 0.
- R5: When no urgent channel is waiting, an ordinary channel is granted at once. Ordinary requesters alone take turns one after another.
- R6: When urgent channels remain eligible but none is left unserved and no ordinary channel requests, a new round begins immediately.
- R7: A channel whose enable bit is 0 is never granted. A held grant disappears from the outputs in the same cycle its channel loses request or enable, and a fresh decision is made at the next edge.
- R8: A grant stays unchanged until accept is sampled high while it is valid. Pointers and round progress change only on such an accept.
- R9: A new grant is presented in the cycle after any edge where no grant was valid or the current one was accepted. If a channel is eligible at that edge, it is never left waiting with an idle issue slot.
- R10: `grant_onehot` has at most one bit set, and `grant_valid` is high exactly when one bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_req | input | NUM_CH | Per-channel transfer request |
| chan_en | input | NUM_CH | Per-channel enable; 0 blocks any grant |
| chan_hipri | input | NUM_CH | Per-channel urgency bit, 1 = urgent class |
| issue_accept | input | 1 | Issue stage takes the presented grant |
| grant_onehot | output | NUM_CH | One-hot selected channel |
| grant_valid | output | 1 | A grant is presented |

## Verification
Two functions can land on the same edge: an accept, which moves a pointer and the round state, and a fresh selection, which must already use those moved values. A further case is a request or enable dropping while its grant is held. Continuous accepts with every channel requesting force an accept and a reselection on every edge, and the bench compares the grant order against a per-round sequence worked out from R2 and R3. Random phases combine random accepts with random enable and request changes. Every cycle is judged against a reference model built from the requirements, and directed cases remove the enable of a held grant to check the withdraw-then-reselect timing.

// File: rtl/dma_sched_pkg.sv
package dma_sched_pkg;

    // index of the channel following i, wrapping at n
    function automatic int wrap_inc(input int i, input int n);
        return (i + 1 >= n) ? 0 : i + 1;
    endfunction

endpackage

// File: rtl/dma_sched_rr_pick.sv
module dma_sched_rr_pick #(
    parameter int NUM_CH = 8,
    localparam int IW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic [NUM_CH-1:0] cand,
    input  logic [IW-1:0]     start,
    output logic [NUM_CH-1:0] pick_oh,
    output logic [IW-1:0]     pick_idx,
    output logic              found
);

    // search from start upward with wrap; the smallest offset wins
    always_comb begin
        found    = 1'b0;
        pick_idx = '0;
        for (int off = NUM_CH - 1; off >= 0; off--) begin
            int p;
            p = int'(start) + off;
            if (p >= NUM_CH) p = p - NUM_CH;
            if (cand[p]) begin
                found    = 1'b1;
                pick_idx = IW'(p);
            end
        end
        pick_oh = found ? (NUM_CH'(1) << pick_idx) : '0;
    end

endmodule

// File: rtl/dma_round_sched.sv
module dma_round_sched #(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] chan_req,
    input  logic [NUM_CH-1:0] chan_en,
    input  logic [NUM_CH-1:0] chan_hipri,
    input  logic              issue_accept,
    output logic [NUM_CH-1:0] grant_onehot,
    output logic              grant_valid
);

    localparam int IW     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int NPICK  = 3;
    localparam int P_HI   = 0;   // unserved urgent channels
    localparam int P_LO   = 1;   // ordinary channels
    localparam int P_NEW  = 2;   // all urgent channels, new round

    typedef struct packed {
        logic [NUM_CH-1:0] gnt;
        logic              gnt_hi;
        logic [IW-1:0]     gidx;
        logic [NUM_CH-1:0] served;
        logic [IW-1:0]     hptr;
        logic [IW-1:0]     lptr;
    } sched_st_t;

    sched_st_t st_q, st_d;

    logic [NUM_CH-1:0] elig;
    logic [NUM_CH-1:0] gnt_live;
    logic              acc;

    // state after the bookkeeping of this cycle's accept
    logic [NUM_CH-1:0] served_u;
    logic [IW-1:0]     hptr_u;
    logic [IW-1:0]     lptr_u;

    logic [NUM_CH-1:0] pk_cand  [NPICK];
    logic [IW-1:0]     pk_start [NPICK];
    logic [NUM_CH-1:0] pk_oh    [NPICK];
    logic [IW-1:0]     pk_idx   [NPICK];
    logic              pk_found [NPICK];

    assign elig         = chan_req & chan_en;
    assign gnt_live     = st_q.gnt & elig;
    assign grant_onehot = gnt_live;
    assign grant_valid  = |gnt_live;
    assign acc          = issue_accept & grant_valid;

    always_comb begin
        served_u = st_q.served;
        hptr_u   = st_q.hptr;
        lptr_u   = st_q.lptr;
        if (acc) begin
            if (st_q.gnt_hi) begin
                served_u = st_q.served | st_q.gnt;
                hptr_u   = IW'(dma_sched_pkg::wrap_inc(int'(st_q.gidx), NUM_CH));
            end else begin
                served_u = '0;
                lptr_u   = IW'(dma_sched_pkg::wrap_inc(int'(st_q.gidx), NUM_CH));
            end
        end
    end

    assign pk_cand[P_HI]   = elig & chan_hipri & ~served_u;
    assign pk_start[P_HI]  = hptr_u;
    assign pk_cand[P_LO]   = elig & ~chan_hipri;
    assign pk_start[P_LO]  = lptr_u;
    assign pk_cand[P_NEW]  = elig & chan_hipri;
    assign pk_start[P_NEW] = hptr_u;

    for (genvar g = 0; g < NPICK; g++) begin : g_pick
        dma_sched_rr_pick #(.NUM_CH(NUM_CH)) u_pick (
            .cand     (pk_cand[g]),
            .start    (pk_start[g]),
            .pick_oh  (pk_oh[g]),
            .pick_idx (pk_idx[g]),
            .found    (pk_found[g])
        );
    end

    always_comb begin
        st_d        = st_q;
        st_d.served = served_u;
        st_d.hptr   = hptr_u;
        st_d.lptr   = lptr_u;
        if (!grant_valid || acc) begin
            if (pk_found[P_HI]) begin
                st_d.gnt    = pk_oh[P_HI];
                st_d.gnt_hi = 1'b1;
                st_d.gidx   = pk_idx[P_HI];
            end else if (pk_found[P_LO]) begin
                st_d.gnt    = pk_oh[P_LO];
                st_d.gnt_hi = 1'b0;
                st_d.gidx   = pk_idx[P_LO];
            end else if (pk_found[P_NEW]) begin
                st_d.gnt    = pk_oh[P_NEW];
                st_d.gnt_hi = 1'b1;
                st_d.gidx   = pk_idx[P_NEW];
                st_d.served = '0;
            end else begin
                st_d.gnt    = '0;
                st_d.gnt_hi = 1'b0;
                st_d.gidx   = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_onehot)); // R10

    AST_GRANT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && !issue_accept) |=>
            (grant_onehot == $past(grant_onehot)) ||
            (($past(grant_onehot) & chan_req & chan_en) == '0)); // R8

    AST_HI_ONCE_PER_ROUND: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && st_q.gnt_hi) |-> ((st_q.gnt & st_q.served) == '0)); // R2

    AST_LO_CLOSES_ROUND: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !st_q.gnt_hi) |=> (st_q.served == '0)); // R3

    AST_NO_IDLE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (!grant_valid && (elig != '0)) |=> (st_q.gnt != '0)); // R9

    AST_ONLY_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.gnt & ~$past(chan_en & chan_req)) == '0)); // R7

endmodule

// File: tb/dma_round_sched_tb.sv
module dma_round_sched_tb;

    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] chan_req = '0;
    logic [N-1:0] chan_en = '0;
    logic [N-1:0] chan_hipri = '0;
    logic         issue_accept = 1'b0;
    logic [N-1:0] grant_onehot;
    logic         grant_valid;

    int n_chk = 0;
    int n_bad = 0;

    // reference model state (m_) and value after the coming edge (n_)
    logic [N-1:0] m_gnt, n_gnt, m_served, n_served;
    bit           m_hi, n_hi;
    int           m_idx, n_idx, m_hp, n_hp, m_lp, n_lp;

    always #5 clk = ~clk;

    dma_round_sched #(.NUM_CH(N)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .chan_req     (chan_req),
        .chan_en      (chan_en),
        .chan_hipri   (chan_hipri),
        .issue_accept (issue_accept),
        .grant_onehot (grant_onehot),
        .grant_valid  (grant_valid)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic int first_from(input logic [N-1:0] v, input int s);
        for (int off = 0; off < N; off++) begin
            if (v[(s + off) % N]) return (s + off) % N;
        end
        return -1;
    endfunction

    function automatic int oh_index(input logic [N-1:0] v);
        for (int i = 0; i < N; i++) if (v[i]) return i;
        return -1;
    endfunction

    // model step for the edge that sees these inputs
    task automatic model_next(input logic [N-1:0] rq, en, hp, input bit ac);
        logic [N-1:0] elig, su;
        bit outv, a;
        int h, l, c;
        elig = rq & en;
        outv = |(m_gnt & elig);
        a    = ac && outv;
        su = m_served; h = m_hp; l = m_lp;
        if (a) begin
            if (m_hi) begin su = su | m_gnt; h = (m_idx + 1) % N; end
            else      begin su = '0;          l = (m_idx + 1) % N; end
        end
        n_served = su; n_hp = h; n_lp = l;
        n_gnt = m_gnt; n_hi = m_hi; n_idx = m_idx;
        if (!outv || a) begin
            c = first_from(elig & hp & ~su, h);
            if (c >= 0) begin n_gnt = N'(1) << c; n_hi = 1; n_idx = c; end
            else begin
                c = first_from(elig & ~hp, l);
                if (c >= 0) begin n_gnt = N'(1) << c; n_hi = 0; n_idx = c; end
                else begin
                    c = first_from(elig & hp, h);
                    if (c >= 0) begin
                        n_gnt = N'(1) << c; n_hi = 1; n_idx = c; n_served = '0;
                    end else begin
                        n_gnt = '0; n_hi = 0; n_idx = 0;
                    end
                end
            end
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; chan_req = '0; chan_en = '0; chan_hipri = '0; issue_accept = 1'b0;
        repeat (3) @(negedge clk);
        m_gnt = '0; m_hi = 0; m_idx = 0; m_served = '0; m_hp = 0; m_lp = 0;
        n_gnt = '0; n_hi = 0; n_idx = 0; n_served = '0; n_hp = 0; n_lp = 0;
        #1;
        check(grant_valid == 1'b0 && grant_onehot == '0, "R1 no grant in reset",
              int'(grant_onehot), 0);
        rst_n = 1'b1;
    endtask

    // one cycle: commit model, drive inputs, compare, precompute next
    task automatic cycle(input logic [N-1:0] rq, en, hp, input bit ac, output int seen);
        logic [N-1:0] exp_oh;
        @(negedge clk);
        m_gnt = n_gnt; m_hi = n_hi; m_idx = n_idx; m_served = n_served;
        m_hp = n_hp; m_lp = n_lp;
        chan_req = rq; chan_en = en; chan_hipri = hp; issue_accept = ac;
        #1;
        exp_oh = m_gnt & rq & en;
        check(grant_onehot == exp_oh && grant_valid == (exp_oh != '0),
              "R2 model grant", int'(grant_onehot), int'(exp_oh));
        check($countones(grant_onehot) <= 1 && grant_valid == (grant_onehot != '0),
              "R10 one-hot/valid", int'(grant_onehot), int'(grant_valid));
        seen = grant_valid ? oh_index(grant_onehot) : -1;
        model_next(rq, en, hp, ac);
    endtask

    function automatic int seq_all(input int k);
        int hi_list[3] = '{1, 3, 6};
        int lo_list[5] = '{0, 2, 4, 5, 7};
        if (k % 4 < 3) return hi_list[k % 4];
        return lo_list[(k / 4) % 5];
    endfunction

    initial begin
        #(200000 * 10);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int seen;
        logic [N-1:0] all1, hmask;
        void'($urandom(32'd7351));
        all1  = '1;
        hmask = 8'b0100_1010;

        // R2/R3/R4: everyone requesting, accept every cycle
        do_reset();
        cycle(all1, all1, hmask, 1'b1, seen);
        check(seen == -1, "R1 first cycle after reset empty", seen, -1);
        for (int k = 0; k < 24; k++) begin
            cycle(all1, all1, hmask, 1'b1, seen);
            check(seen == seq_all(k), "R3 round order", seen, seq_all(k));
        end

        // R5/R9: ordinary channels 2 and 5 only
        do_reset();
        cycle(8'b0010_0100, all1, '0, 1'b1, seen);
        for (int k = 0; k < 8; k++) begin
            cycle(8'b0010_0100, all1, '0, 1'b1, seen);
            check(seen == ((k % 2 == 0) ? 2 : 5), "R5 ordinary alone", seen,
                  (k % 2 == 0) ? 2 : 5);
        end

        // R6: urgent channels 1 and 3 only
        do_reset();
        cycle(8'b0000_1010, all1, 8'b0000_1010, 1'b1, seen);
        for (int k = 0; k < 8; k++) begin
            cycle(8'b0000_1010, all1, 8'b0000_1010, 1'b1, seen);
            check(seen == ((k % 2 == 0) ? 1 : 3), "R6 new round", seen,
                  (k % 2 == 0) ? 1 : 3);
        end

        // R7: requests with enable low, then enable
        do_reset();
        for (int k = 0; k < 5; k++) begin
            cycle(all1, '0, hmask, 1'b1, seen);
            check(seen == -1, "R7 disabled never granted", seen, -1);
        end
        cycle(all1, all1, hmask, 1'b0, seen);
        check(seen == -1, "R9 decision one edge later", seen, -1);
        cycle(all1, all1, hmask, 1'b0, seen);
        check(seen == 1, "R9 grant after enable", seen, 1);

        // R8: hold without accept, then accept, then withdraw
        do_reset();
        cycle(all1, all1, hmask, 1'b0, seen);
        for (int k = 0; k < 5; k++) begin
            cycle(all1, all1, hmask, 1'b0, seen);
            check(seen == 1, "R8 grant held", seen, 1);
        end
        cycle(all1, all1, hmask, 1'b1, seen);
        check(seen == 1, "R8 accepted grant", seen, 1);
        cycle(all1, all1, hmask, 1'b0, seen);
        check(seen == 3, "R4 next urgent after accept", seen, 3);
        cycle(all1, 8'b1111_0111, hmask, 1'b0, seen);
        check(seen == -1, "R7 withdrawn on enable drop", seen, -1);
        cycle(all1, 8'b1111_0111, hmask, 1'b0, seen);
        check(seen == 6, "R7 reselect skips disabled", seen, 6);

        // random phase against the model
        do_reset();
        for (int k = 0; k < 4000; k++) begin
            logic [N-1:0] rq, en;
            if (k % 150 == 0) hmask = N'($urandom);
            rq = N'($urandom) | N'($urandom);
            en = ~(N'($urandom) & N'($urandom) & N'($urandom));
            if (k % 500 < 100) begin rq = '1; en = '1; end
            cycle(rq, en, hmask, ($urandom % 10) < 7, seen);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule